// File: doc/BRIEF.md
# PCI and SRC Clock Stop Gate

This block sits behind the clock dividers and decides, cycle by cycle, which PCI-rate clocks and which differential SRC clock pair reach the pins. A stop request comes from either of two places. One is an active-low stop pin. The other is a register bit, where a value of 0 also means "stop".

The request is captured on the rising edge of the free-running PCI source clock. The stop then happens in a fixed order:

- Every stoppable single-ended PCI clock is held low from one of its falling edges onward.
- Only after that does the SRC pair park on a rising edge of its own source clock.

Three of the PCI-rate outputs can each be made free-running. A free-running output ignores both the pin and the register bit. Every PCI-rate output also has an enable bit of its own. When the request goes away, the same path runs in reverse. Each clock is switched back on only at a point where switching cannot create a shortened high pulse.

The SRC pair reports its drive state as a 2-bit code next to its true and complement values. The pad logic uses this code to choose between running, driven park and high impedance.

Top module: `pci_src_stop_gate`

## Requirements
- R1: While rst_ni is low, every PCI and free-running-capable output is low and src_state_o is 2'b00 (running).
- R2: The stop request is active when stop_ni is 0 or stop_bit_i is 0. It passes through SYNC_STAGES flops clocked on the rising edge of pci_clk_i, and each of the two sources alone stops the clocks.
- R3: A stoppable PCI output follows pci_clk_i while running. It goes low at the first falling edge of pci_clk_i after the synchronised request is set, and it never shows a high pulse shorter than the high phase of pci_clk_i.
- R4: A free-running-capable output whose bit in pcif_stoppable_i is 0 keeps toggling whatever the stop request. With the bit at 1, it stops like a plain PCI output.
- R5: An output whose enable bit is 0 is held low from the next falling edge of pci_clk_i. The other outputs keep running.
- R6: The SRC pair parks only after the PCI stop flag has been set on a falling edge of pci_clk_i. The flag is then carried through SYNC_STAGES flops on rising edges of src_clk_i. With src_tri_i at 0 the parked pair shows src_t_o=1, src_c_o=0 and src_state_o=2'b01.
- R7: With src_tri_i at 1 the parked pair shows src_state_o=2'b10, with src_t_o and src_c_o both 0.
- R8: With src_stoppable_i at 0 the SRC pair keeps running (src_state_o=2'b00) while the PCI outputs stop.
- R9: When the request clears, the PCI outputs re-enable at a falling edge of pci_clk_i and SRC leaves park at a rising edge of src_clk_i. While running, src_t_o follows src_clk_i and src_c_o is its inverse.
- R10: With SYNC_STAGES=2, the SRC pair is parked at the second rising edge of src_clk_i after the falling edge of pci_clk_i that sets the PCI stop flag. This is within one PCI period when src_clk_i runs four times faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| pci_clk_i | input | 1 | Free-running PCI source clock |
| src_clk_i | input | 1 | SRC source clock |
| stop_ni | input | 1 | Active-low stop pin |
| stop_bit_i | input | 1 | Register stop bit, 0 stops |
| pci_oe_i | input | NUM_PCI | Enable for each plain PCI output |
| pcif_oe_i | input | NUM_PCIF | Enable for each free-running-capable output |
| pcif_stoppable_i | input | NUM_PCIF | 1 = stoppable, 0 = free-running |
| src_stoppable_i | input | 1 | 1 = SRC pair stops with the request |
| src_tri_i | input | 1 | 1 = parked SRC pair is high impedance |
| pci_o | output | NUM_PCI | Gated plain PCI clocks |
| pcif_o | output | NUM_PCIF | Gated free-running-capable clocks |
| src_t_o | output | 1 | SRC true output value |
| src_c_o | output | 1 | SRC complement output value |
| src_state_o | output | 2 | SRC drive code: 00 run, 01 parked driven, 10 high impedance |

## Verification
A gate enable that switched on the wrong edge would show at the ports within half a PCI period. It would appear as a shortened high pulse, or as a missing pulse, when compared with the reference waveform, which the bench samples every nanosecond.

A synchroniser of the wrong length or a wrong park flag would move the SRC park edge by one or more src_clk_i cycles. The bench measures that latency directly. Mishandling of the free-running bits, the enable bits or the tristate code would show up as a wrong level during the next high phase of the source clock.

// File: rtl/pci_stop_pkg.sv
`timescale 1ns/100ps
package pci_stop_pkg;
  typedef enum logic [1:0] {
    SRC_RUN  = 2'b00,
    SRC_PARK = 2'b01,
    SRC_TRI  = 2'b10
  } src_state_e;
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/100ps
module stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/clk_gate_low.sv
`timescale 1ns/100ps
module clk_gate_low #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_i,
  input  logic [N-1:0] oe_i,
  input  logic [N-1:0] stoppable_i,
  output logic [N-1:0] gclk_o
);
  logic [N-1:0] en_q;
  logic         seen_q;

  // enable only moves while the source is low: no runt pulses
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_gate
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[g] <= 1'b0;
      else         en_q[g] <= oe_i[g] & ~(stop_i & stoppable_i[g]);
    end

    assign gclk_o[g] = clk_i & en_q[g];

    AST_DISABLED_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (seen_q && !oe_i[g] && $past(!oe_i[g])) |-> !gclk_o[g]); // R5

    AST_FREE_RUN_HIGH: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (seen_q && oe_i[g] && !stoppable_i[g] && $past(oe_i[g] && !stoppable_i[g]))
      |-> gclk_o[g]); // R4
  end
endmodule

// File: rtl/src_park_ctrl.sv
`timescale 1ns/100ps
module src_park_ctrl
  import pci_stop_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       src_clk_i,
  input  logic       rst_ni,
  input  logic       pci_stopped_i,
  input  logic       stoppable_i,
  input  logic       tri_i,
  output logic       src_t_o,
  output logic       src_c_o,
  output src_state_e state_o
);
  logic [STAGES-2:0] ss_q;
  logic              park_q;

  // last synchroniser stage doubles as the park flop
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q   <= '0;
      park_q <= 1'b0;
    end else begin
      ss_q[0] <= pci_stopped_i;
      for (int k = 1; k < STAGES-1; k++) ss_q[k] <= ss_q[k-1];
      park_q  <= ss_q[STAGES-2] & stoppable_i;
    end
  end

  always_comb begin
    if (!park_q)    state_o = SRC_RUN;
    else if (tri_i) state_o = SRC_TRI;
    else            state_o = SRC_PARK;
  end

  always_comb begin
    unique case (state_o)
      SRC_PARK: begin src_t_o = 1'b1;       src_c_o = 1'b0;        end
      SRC_TRI:  begin src_t_o = 1'b0;       src_c_o = 1'b0;        end
      default:  begin src_t_o = src_clk_i;  src_c_o = ~src_clk_i;  end
    endcase
  end

  AST_PARK_AFTER_PCI: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $rose(park_q) |-> $past(pci_stopped_i, STAGES)); // R6

  AST_PARK_LEVELS: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    (state_o == SRC_PARK) |-> (src_t_o && !src_c_o)); // R6

  AST_TRI_QUIET: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    (state_o == SRC_TRI) |-> (!src_t_o && !src_c_o)); // R7

  AST_RUN_COMPLEMENT: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    (state_o == SRC_RUN) |-> (src_t_o != src_c_o)); // R9
endmodule

// File: rtl/pci_src_stop_gate.sv
`timescale 1ns/100ps
module pci_src_stop_gate
  import pci_stop_pkg::*;
#(
  parameter int NUM_PCI     = 7,
  parameter int NUM_PCIF    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rst_ni,
  input  logic                pci_clk_i,
  input  logic                src_clk_i,
  input  logic                stop_ni,
  input  logic                stop_bit_i,
  input  logic [NUM_PCI-1:0]  pci_oe_i,
  input  logic [NUM_PCIF-1:0] pcif_oe_i,
  input  logic [NUM_PCIF-1:0] pcif_stoppable_i,
  input  logic                src_stoppable_i,
  input  logic                src_tri_i,
  output logic [NUM_PCI-1:0]  pci_o,
  output logic [NUM_PCIF-1:0] pcif_o,
  output logic                src_t_o,
  output logic                src_c_o,
  output logic [1:0]          src_state_o
);
  localparam logic [NUM_PCI-1:0] PCI_ALL_STOPPABLE = '1;

  logic       stop_raw;
  logic       stop_sync_pci;
  logic       pci_stopped_q;
  src_state_e src_state;

  assign stop_raw = ~stop_ni | ~stop_bit_i;

  stop_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (pci_clk_i),
    .rst_ni (rst_ni),
    .d_i    (stop_raw),
    .q_o    (stop_sync_pci)
  );

  clk_gate_low #(.N(NUM_PCI)) u_pci_gate (
    .clk_i       (pci_clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_sync_pci),
    .oe_i        (pci_oe_i),
    .stoppable_i (PCI_ALL_STOPPABLE),
    .gclk_o      (pci_o)
  );

  clk_gate_low #(.N(NUM_PCIF)) u_pcif_gate (
    .clk_i       (pci_clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_sync_pci),
    .oe_i        (pcif_oe_i),
    .stoppable_i (pcif_stoppable_i),
    .gclk_o      (pcif_o)
  );

  // set on the same falling edge that latches the PCI gates low
  always_ff @(negedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) pci_stopped_q <= 1'b0;
    else         pci_stopped_q <= stop_sync_pci;
  end

  src_park_ctrl #(.STAGES(SYNC_STAGES)) u_src (
    .src_clk_i     (src_clk_i),
    .rst_ni        (rst_ni),
    .pci_stopped_i (pci_stopped_q),
    .stoppable_i   (src_stoppable_i),
    .tri_i         (src_tri_i),
    .src_t_o       (src_t_o),
    .src_c_o       (src_c_o),
    .state_o       (src_state)
  );

  assign src_state_o = src_state;

  AST_STOPPED_PCI_LOW: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    ($past(pci_stopped_q) && pci_stopped_q) |-> (pci_o == '0)); // R3
endmodule

// File: tb/pci_src_stop_gate_test.sv
`timescale 1ns/100ps
module pci_src_stop_gate_test;
  logic       rst_n = 1'b0;
  logic       pci_clk = 1'b0;
  logic       src_clk = 1'b0;
  logic       stop_n = 1'b1;
  logic       stop_bit = 1'b1;
  logic [6:0] pci_oe = 7'h7f;
  logic [2:0] pcif_oe = 3'b111;
  logic [2:0] pcif_stoppable = 3'b010;
  logic       src_stoppable = 1'b1;
  logic       src_tri = 1'b0;
  logic [6:0] pci_o;
  logic [2:0] pcif_o;
  logic       src_t, src_c;
  logic [1:0] src_state;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pci_src_stop_gate uut (
    .rst_ni(rst_n), .pci_clk_i(pci_clk), .src_clk_i(src_clk),
    .stop_ni(stop_n), .stop_bit_i(stop_bit),
    .pci_oe_i(pci_oe), .pcif_oe_i(pcif_oe), .pcif_stoppable_i(pcif_stoppable),
    .src_stoppable_i(src_stoppable), .src_tri_i(src_tri),
    .pci_o(pci_o), .pcif_o(pcif_o), .src_t_o(src_t), .src_c_o(src_c),
    .src_state_o(src_state)
  );

  // 250 MHz SRC source; PCI source at a quarter of that, edges offset by 1 ns
  initial forever #2 src_clk = ~src_clk;
  initial begin #3; forever begin pci_clk = ~pci_clk; #8; end end

  // behavioural reference
  logic [1:0] m_req;
  logic       m_flag, m_ss, m_park;
  logic [6:0] m_pen;
  logic [2:0] m_fen;

  always @(posedge pci_clk or negedge rst_n)
    if (!rst_n) m_req <= 2'b00;
    else        m_req <= {m_req[0], (!stop_n) || (!stop_bit)};

  always @(negedge pci_clk or negedge rst_n)
    if (!rst_n) begin
      m_pen <= '0; m_fen <= '0; m_flag <= 1'b0;
    end else begin
      m_flag <= m_req[1];
      for (int i = 0; i < 7; i++) m_pen[i] <= pci_oe[i] && !m_req[1];
      for (int i = 0; i < 3; i++) m_fen[i] <= pcif_oe[i] && !(m_req[1] && pcif_stoppable[i]);
    end

  always @(posedge src_clk or negedge rst_n)
    if (!rst_n) begin m_ss <= 1'b0; m_park <= 1'b0; end
    else begin m_ss <= m_flag; m_park <= m_ss && src_stoppable; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference every nanosecond, between edges
  initial begin
    #0.5;
    forever begin
      logic [6:0] e_pci;
      logic [2:0] e_pcif;
      logic [3:0] e_src;
      e_pci  = {7{pci_clk}} & m_pen;
      e_pcif = {3{pci_clk}} & m_fen;
      e_src  = m_park ? (src_tri ? 4'b0010 : 4'b1001) : {src_clk, ~src_clk, 2'b00};
      chk(pci_o == e_pci, "R3 pci waveform", 32'(pci_o), 32'(e_pci));
      chk(pcif_o == e_pcif, "R4 pcif waveform", 32'(pcif_o), 32'(e_pcif));
      chk({src_t, src_c, src_state} == e_src, "R6 src waveform",
          32'({src_t, src_c, src_state}), 32'(e_src));
      #1;
    end
  end

  task automatic step();
    @(posedge src_clk); #0.7;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge src_clk);
    #0.5;
  endtask

  task automatic at_pci_high();
    @(posedge pci_clk); #0.5;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    settle(3);
    chk(pci_o == 0, "R1 pci in reset", 32'(pci_o), 0);
    chk(pcif_o == 0, "R1 pcif in reset", 32'(pcif_o), 0);
    chk(src_state == 2'b00, "R1 src state in reset", 32'(src_state), 0);
    step(); rst_n = 1'b1;
    settle(20);
    at_pci_high();
    chk(pci_o == 7'h7f, "R9 running after reset", 32'(pci_o), 32'h7f);

    // pin stop and SRC park latency
    step(); stop_n = 1'b0;
    wait (m_flag == 1'b1);
    n = 0;
    while (src_state != 2'b01 && n < 10) begin @(posedge src_clk); #0.3; n++; end
    chk(n == 2, "R10 src park latency", 32'(n), 2);
    settle(10);
    at_pci_high();
    chk(pci_o == 0, "R3 pci stopped low", 32'(pci_o), 0);
    chk(pcif_o == 3'b101, "R4 free-running keep toggling", 32'(pcif_o), 32'h5);
    chk({src_t, src_c, src_state} == 4'b1001, "R6 parked driven", 32'({src_t, src_c, src_state}), 32'h9);

    step(); stop_n = 1'b1;
    settle(30);
    at_pci_high();
    chk(pci_o == 7'h7f, "R9 pci resumed", 32'(pci_o), 32'h7f);
    chk(src_state == 2'b00, "R9 src resumed", 32'(src_state), 0);

    // register bit stop
    step(); stop_bit = 1'b0;
    settle(30);
    at_pci_high();
    chk(pci_o == 0, "R2 bit stops pci", 32'(pci_o), 0);
    chk(src_state == 2'b01, "R2 bit parks src", 32'(src_state), 1);
    step(); stop_bit = 1'b1;
    settle(30);

    // tristate park
    step(); src_tri = 1'b1; stop_n = 1'b0;
    settle(30);
    chk({src_t, src_c, src_state} == 4'b0010, "R7 tristate park", 32'({src_t, src_c, src_state}), 32'h2);
    step(); stop_n = 1'b1;
    settle(30);
    chk(src_state == 2'b00, "R9 leave tristate park", 32'(src_state), 0);
    step(); src_tri = 1'b0;

    // SRC free-running
    step(); src_stoppable = 1'b0; stop_n = 1'b0;
    settle(30);
    at_pci_high();
    chk(src_state == 2'b00, "R8 src keeps running", 32'(src_state), 0);
    chk(pci_o == 0, "R8 pci still stopped", 32'(pci_o), 0);
    step(); stop_n = 1'b1; src_stoppable = 1'b1;
    settle(30);

    // per-output enables
    step(); pci_oe[3] = 1'b0; pcif_oe[1] = 1'b0;
    settle(30);
    at_pci_high();
    chk(pci_o == 7'h77, "R5 disabled pci low", 32'(pci_o), 32'h77);
    chk(pcif_o == 3'b101, "R5 disabled pcif low", 32'(pcif_o), 32'h5);
    step(); pci_oe = 7'h7f; pcif_oe = 3'b111;

    // all free-running-capable outputs stoppable
    step(); pcif_stoppable = 3'b111; stop_n = 1'b0;
    settle(30);
    at_pci_high();
    chk(pcif_o == 0, "R4 stoppable pcif stopped", 32'(pcif_o), 0);
    step(); stop_n = 1'b1;
    settle(30);
    at_pci_high();
    chk(pcif_o == 3'b111, "R9 pcif resumed", 32'(pcif_o), 32'h7);

    report();
  end
endmodule